// File: doc/BRIEF.md
# Processor Status and Reset-Cause Register

This block is an 8-bit status and control register that sits beside a small processor core. It holds the run and suspend controls. It keeps sticky flags that tell firmware what caused the last reset: power-on, watchdog, or a reset driven on the upstream bus. It mirrors the core's interrupt-enable state and flags an interrupt that has been recognised but not yet taken.

The register decodes the upstream bus reset by itself. It counts consecutive core-clock cycles in which both bus data lines are low. The power-on reset is asynchronous. The watchdog reset is a synchronous strobe. Halt, interrupt enable, disable and return, and the interrupt recognise and take events arrive from the core as single-cycle strobes.

Firmware reads the register at any time through `rd_data` and writes it with a one-cycle `wr_en`. The `wake` output tells the clock and power logic that a suspended device must resume.

Top module: `cpu_status_reg`

## Requirements
- R1: While `por_n` is low, and after it is released, the register reads 8'h11. The bit layout is: bit0 run, bit1 reserved, bit2 interrupt-enable sense, bit3 suspend, bit4 power-on flag, bit5 bus-reset flag, bit6 watchdog flag, bit7 interrupt pending.
- R2: A `wdt_rst` strobe sets run and the watchdog flag. It keeps the power-on and bus-reset flags and clears the interrupt-enable, suspend and pending bits. Directly after power-on, the register then reads 8'h51.
- R3: A `halt_strb` clears all eight bits. After that, writes to the run bit have no effect until the next power-on or watchdog reset.
- R4: Bit2 is set by `ei_strb` or `reti_strb` and cleared by `di_strb`. When disable and enable arrive in the same cycle, disable wins. A write never changes bit2.
- R5: The bus-reset flag is set at the clock edge that samples the THR-th consecutive cycle with `dp` and `dm` both low, where THR = 12 × `CLK_MHZ`. An SE0 that lasts fewer cycles leaves the flag clear. One unbroken SE0 sets the flag only once, even if firmware clears it during the SE0.
- R6: Writing bit3 = 1 enters suspend, unless `bus_active` is high in that cycle, in which case the register stays out of suspend. Writing bit3 = 0 leaves or stays out of suspend.
- R7: `wake` is high, without a clock delay, while suspend is set and either `irq_wake` or `bus_active` is high. Suspend is cleared at the next edge. The `run` output is low while suspend is set.
- R8: Bit7 is set by `irq_seen` and cleared by `irq_taken`. When both arrive in the same cycle, set wins. Writes never change bit7.
- R9: Bit1 always reads 0, whatever is written.
- R10: A write of 0 clears bits 4, 5 and 6, and a write of 1 leaves them unchanged. A hardware set of the bus-reset flag wins over a write clear in the same cycle.
- R11: The events are prioritised: power-on above watchdog, watchdog above halt, halt above every other event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wdt_rst | input | 1 | Watchdog reset strobe |
| halt_strb | input | 1 | Halt instruction executed |
| ei_strb | input | 1 | Enable-interrupt instruction executed |
| di_strb | input | 1 | Disable-interrupt instruction executed |
| reti_strb | input | 1 | Return-from-interrupt executed |
| irq_seen | input | 1 | An interrupt has been recognised |
| irq_taken | input | 1 | Interrupt handling sequence took the interrupt |
| irq_wake | input | 1 | An enabled interrupt is pending (wakes from suspend) |
| dp | input | 1 | Upstream bus data line plus, synchronous |
| dm | input | 1 | Upstream bus data line minus, synchronous |
| bus_active | input | 1 | Upstream bus activity seen |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| run | output | 1 | Processor may execute |
| suspend | output | 1 | Device is in suspend |
| wake | output | 1 | Resume request while suspended |

## Verification
The bench first targets the SE0 threshold.
- An SE0 one cycle shorter than THR must leave the bus-reset flag clear, so a counter that is off by one fails here.
- Firmware clears the flag while the SE0 is still held. A detector that re-arms on a level would set the flag a second time.

The remaining directed cases each catch one wrong priority or one lost latch.
- A suspend write made while the bus is active must be dropped.
- A halt must lock the run bit against later writes.
- A watchdog strobe and a halt in the same cycle must leave the watchdog state, not zero.
- Disable and enable in the same cycle must leave interrupts disabled.

Random stimulus then mixes all the strobes against a reference model to expose misordered updates.

// File: rtl/cpu_status_reg.sv
module cpu_status_reg #(
  parameter int CLK_MHZ = 12
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       wdt_rst,
  input  logic       halt_strb,
  input  logic       ei_strb,
  input  logic       di_strb,
  input  logic       reti_strb,
  input  logic       irq_seen,
  input  logic       irq_taken,
  input  logic       irq_wake,
  input  logic       dp,
  input  logic       dm,
  input  logic       bus_active,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       run,
  output logic       suspend,
  output logic       wake
);

  localparam int THR = 12 * CLK_MHZ;
  localparam int CW  = $clog2(THR + 1);

  logic run_q, ie_q, susp_q, por_q, bus_q, wdt_q, irq_q, halted_q;
  logic [CW-1:0] se0_cnt;

  wire se0     = !dp && !dm;
  wire se0_hit = se0 && (se0_cnt == CW'(THR - 1));

  assign rd_data = {irq_q, wdt_q, bus_q, por_q, susp_q, ie_q, 1'b0, run_q};
  assign wake    = susp_q && (irq_wake || bus_active);
  assign suspend = susp_q;
  assign run     = run_q && !susp_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      se0_cnt <= '0;
    else if (wdt_rst || !se0)
      se0_cnt <= '0;
    else if (se0_cnt != CW'(THR))
      se0_cnt <= se0_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      run_q <= 1'b1; ie_q <= 1'b0; susp_q <= 1'b0; por_q <= 1'b1;
      bus_q <= 1'b0; wdt_q <= 1'b0; irq_q <= 1'b0; halted_q <= 1'b0;
    end else if (wdt_rst) begin
      run_q <= 1'b1; ie_q <= 1'b0; susp_q <= 1'b0; wdt_q <= 1'b1;
      irq_q <= 1'b0; halted_q <= 1'b0;
    end else if (halt_strb) begin
      run_q <= 1'b0; ie_q <= 1'b0; susp_q <= 1'b0; por_q <= 1'b0;
      bus_q <= 1'b0; wdt_q <= 1'b0; irq_q <= 1'b0; halted_q <= 1'b1;
    end else begin
      if (wr_en && !halted_q) run_q <= wr_data[0];
      if (wr_en) begin
        por_q <= por_q && wr_data[4];
        wdt_q <= wdt_q && wr_data[6];
      end
      bus_q <= se0_hit || (bus_q && !(wr_en && !wr_data[5]));
      if (di_strb) ie_q <= 1'b0;
      else if (ei_strb || reti_strb) ie_q <= 1'b1;
      if (irq_seen) irq_q <= 1'b1;
      else if (irq_taken) irq_q <= 1'b0;
      if (wake) susp_q <= 1'b0;
      else if (wr_en) susp_q <= wr_data[3] && !bus_active;
    end
  end

  AST_HALT_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    (halt_strb && !wdt_rst) |=> (rd_data == 8'h00)); // R3

  AST_HALT_LOCKS_RUN: assert property (@(posedge clk) disable iff (!por_n)
    (halted_q && !wdt_rst) |=> !run_q); // R3

  AST_WDT_SETS: assert property (@(posedge clk) disable iff (!por_n)
    wdt_rst |=> (rd_data[6] && rd_data[0] && !rd_data[3] && !rd_data[7])); // R2

  AST_IE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
    (!ei_strb && !di_strb && !reti_strb && !halt_strb && !wdt_rst) |=> $stable(ie_q)); // R4

  AST_NO_SE0_NO_FLAG: assert property (@(posedge clk) disable iff (!por_n)
    ((dp || dm) && !bus_q) |=> !bus_q); // R5

  AST_SUSP_BLOCKED: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && bus_active && !susp_q && !halt_strb && !wdt_rst) |=> !susp_q); // R6

  AST_WAKE_EXITS: assert property (@(posedge clk) disable iff (!por_n)
    (susp_q && wake) |=> !susp_q); // R7

  AST_RUN_LOW_SUSP: assert property (@(posedge clk) disable iff (!por_n)
    susp_q |-> !run); // R7

endmodule

// File: tb/cpu_status_reg_test.sv
module cpu_status_reg_test;
  localparam int MHZ = 2;
  localparam int THR = 12 * MHZ;

  logic clk = 0, por_n = 0, wdt_rst = 0, halt_strb = 0, ei_strb = 0, di_strb = 0;
  logic reti_strb = 0, irq_seen = 0, irq_taken = 0, irq_wake = 0, dp = 1, dm = 0;
  logic bus_active = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic run, suspend, wake;

  int checks = 0, fails = 0;
  bit done = 0;

  logic e_run, e_ie, e_susp, e_por, e_bus, e_wdt, e_irq, e_halt;
  int e_cnt;

  always #10 clk = ~clk;

  cpu_status_reg #(.CLK_MHZ(MHZ)) uut (
    .clk(clk), .por_n(por_n), .wdt_rst(wdt_rst), .halt_strb(halt_strb),
    .ei_strb(ei_strb), .di_strb(di_strb), .reti_strb(reti_strb),
    .irq_seen(irq_seen), .irq_taken(irq_taken), .irq_wake(irq_wake),
    .dp(dp), .dm(dm), .bus_active(bus_active), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .run(run), .suspend(suspend), .wake(wake));

  function automatic logic [7:0] exp_reg();
    return {e_irq, e_wdt, e_bus, e_por, e_susp, e_ie, 1'b0, e_run};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_por();
    e_run = 1; e_ie = 0; e_susp = 0; e_por = 1; e_bus = 0; e_wdt = 0;
    e_irq = 0; e_halt = 0; e_cnt = 0;
  endtask

  task automatic model_step();
    logic se0, hit, wk;
    se0 = !dp && !dm;
    hit = se0 && (e_cnt == THR - 1);
    wk  = e_susp && (irq_wake || bus_active);
    if (wdt_rst) begin
      e_run = 1; e_ie = 0; e_susp = 0; e_wdt = 1; e_irq = 0; e_halt = 0;
    end else if (halt_strb) begin
      e_run = 0; e_ie = 0; e_susp = 0; e_por = 0; e_bus = 0; e_wdt = 0;
      e_irq = 0; e_halt = 1;
    end else begin
      if (wr_en && !e_halt) e_run = wr_data[0];
      if (wr_en) begin e_por = e_por & wr_data[4]; e_wdt = e_wdt & wr_data[6]; end
      e_bus = hit | (e_bus & !(wr_en && !wr_data[5]));
      if (di_strb) e_ie = 0; else if (ei_strb || reti_strb) e_ie = 1;
      if (irq_seen) e_irq = 1; else if (irq_taken) e_irq = 0;
      if (wk) e_susp = 0; else if (wr_en) e_susp = wr_data[3] && !bus_active;
    end
    if (wdt_rst || !se0) e_cnt = 0;
    else if (e_cnt < THR) e_cnt++;
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check({tag, " reg"}, rd_data, exp_reg());
    check({tag, " run"}, {7'd0, run}, {7'd0, e_run & ~e_susp});
    check({tag, " susp"}, {7'd0, suspend}, {7'd0, e_susp});
    check({tag, " wake"}, {7'd0, wake}, {7'd0, e_susp & (irq_wake | bus_active)});
  endtask

  task automatic idle();
    wdt_rst = 0; halt_strb = 0; ei_strb = 0; di_strb = 0; reti_strb = 0;
    irq_seen = 0; irq_taken = 0; wr_en = 0;
  endtask

  task automatic wr(logic [7:0] d, string tag);
    idle(); wr_en = 1; wr_data = d; tick(tag); idle();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    model_por();
    repeat (3) @(negedge clk);
    check("R1 por value", rd_data, 8'h11);
    check("R1 run out", {7'd0, run}, 8'h01);
    por_n = 1;
    tick("R1 after release");
    check("R1 held", rd_data, 8'h11);

    wdt_rst = 1; tick("R2"); idle();
    check("R2 wdt after por", rd_data, 8'h51);

    wr(8'hF1, "R10 write ones");
    check("R10 ones keep", rd_data, 8'h51);
    wr(8'h01, "R10 write zeros");
    check("R10 zeros clear", rd_data, 8'h01);
    wr(8'h03, "R9");
    check("R9 reserved reads 0", rd_data, 8'h01);
    wr(8'h05, "R4 write");
    check("R4 write ignored", rd_data, 8'h01);

    ei_strb = 1; tick("R4 ei"); idle();
    check("R4 ei sets", rd_data, 8'h05);
    di_strb = 1; ei_strb = 1; tick("R4 di+ei"); idle();
    check("R4 di wins", rd_data, 8'h01);
    reti_strb = 1; tick("R4 reti"); idle();
    check("R4 reti sets", rd_data, 8'h05);
    di_strb = 1; tick("R4 di"); idle();

    irq_seen = 1; tick("R8 seen"); idle();
    check("R8 set", rd_data, 8'h81);
    wr(8'h01, "R8 write");
    check("R8 write ignored", rd_data, 8'h81);
    irq_seen = 1; irq_taken = 1; tick("R8 both"); idle();
    check("R8 set wins", rd_data, 8'h81);
    irq_taken = 1; tick("R8 taken"); idle();
    check("R8 cleared", rd_data, 8'h01);

    dp = 0; dm = 0;
    repeat (THR - 1) tick("R5 short");
    check("R5 below threshold", rd_data, 8'h01);
    tick("R5 hit");
    check("R5 at threshold", rd_data, 8'h21);
    wr(8'h01, "R5 clear during se0");
    tick("R5 held");
    check("R5 once per event", rd_data, 8'h01);
    dp = 1; tick("R5 end");
    dp = 0; repeat (THR - 1) tick("R5 short2");
    dp = 1; tick("R5 short2 end");
    check("R5 short pulse", rd_data, 8'h01);

    dp = 0; repeat (THR - 1) tick("R10 se0");
    wr(8'h01, "R10 set beats clear");
    check("R10 set wins", rd_data, 8'h21);
    dp = 1; wr(8'h01, "R10 cleanup");

    bus_active = 1; wr(8'h09, "R6 busy");
    check("R6 write dropped", rd_data, 8'h01);
    bus_active = 0; wr(8'h09, "R6 enter");
    check("R6 entered", rd_data, 8'h09);
    check("R7 run low", {7'd0, run}, 8'h00);
    tick("R7 stays");
    check("R7 no wake", {7'd0, wake}, 8'h00);
    irq_wake = 1; #1;
    check("R7 wake comb", {7'd0, wake}, 8'h01);
    tick("R7 exit");
    irq_wake = 0;
    check("R7 suspend cleared", rd_data, 8'h01);
    check("R7 run back", {7'd0, run}, 8'h01);
    wr(8'h09, "R7 re-enter");
    bus_active = 1; tick("R7 bus wake"); bus_active = 0;
    check("R7 bus wake", rd_data, 8'h01);

    wdt_rst = 1; halt_strb = 1; tick("R11"); idle();
    check("R11 wdt beats halt", rd_data, 8'h41);

    halt_strb = 1; tick("R3 halt"); idle();
    check("R3 halt clears", rd_data, 8'h00);
    wr(8'h01, "R3 locked");
    check("R3 run locked", rd_data, 8'h00);
    wdt_rst = 1; tick("R3 wdt"); idle();
    check("R3 wdt releases", rd_data, 8'h41);

    for (int i = 0; i < 4000; i++) begin
      wdt_rst   = ($urandom_range(0, 79) == 0);
      halt_strb = ($urandom_range(0, 59) == 0);
      ei_strb   = ($urandom_range(0, 7) == 0);
      di_strb   = ($urandom_range(0, 7) == 0);
      reti_strb = ($urandom_range(0, 9) == 0);
      irq_seen  = ($urandom_range(0, 7) == 0);
      irq_taken = ($urandom_range(0, 7) == 0);
      irq_wake  = ($urandom_range(0, 9) == 0);
      bus_active = ($urandom_range(0, 5) == 0);
      wr_en     = ($urandom_range(0, 3) == 0);
      wr_data   = 8'($urandom);
      if ($urandom_range(0, 29) == 0) begin
        if (!dp && !dm) begin dp = 1; dm = 1'($urandom); end
        else begin dp = 0; dm = 0; end
      end
      tick("RND model");
    end
    idle();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule